// File: doc/BRIEF.md
# Configurable-Format Serial Transceiver

This block is a full-duplex asynchronous serial port with one transmit wire and one receive wire. Bytes to send enter through a valid/ready port and wait in an internal transmit buffer. Received bytes leave through a second valid/ready port from an internal receive buffer. Both directions run at the same time and use one shared bit-rate divisor.

Configuration inputs select the character format at run time. A frame carries 7 or 8 data bits and 1 or 2 stop bits. The parity slot holds nothing, even parity, odd parity, a constant one or a constant zero. The receiver oversamples the line sixteen times per bit and checks that a start bit is real before it accepts it. It reports parity mismatches, broken stop bits and lost bytes on three sticky flags. The flags stay set until the host pulses a clear input.

The shared divisor sets the sixteen-times sample rate: one sample tick every `cfg_div + 1` clocks. A 48 MHz clock with `cfg_div = 25` gives about 115200 bit/s.

Top module: `flex_uart`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1, `rx_valid` is 0 and all three error flags are 0.
- R2: A transmitted frame begins with a low start bit and sends the data bits least significant first. Every bit lasts 16*(`cfg_div`+1) clocks and the line rests high between frames. The format is captured when a frame starts.
- R3: With `cfg_eight`=1 a frame carries 8 data bits. With `cfg_eight`=0 it carries 7: the transmitter does not send `tx_data[7]` and received bytes read with `rx_data[7]`=0.
- R4: With `cfg_two_stop`=1 the transmitter sends two high stop bits, otherwise one. The receiver checks only the first stop position.
- R5: `cfg_parity` selects the parity slot, which directly follows the last data bit. The encodings are: 0 none; 1 even (data plus parity bit hold an even number of ones); 2 odd (they hold an odd number of ones); 3 mark (always 1); 4 space (always 0). Codes 5 to 7 act as none. The receiver checks the slot in all four parity modes.
- R6: The receiver accepts a start bit only if the line is still low 8 sample ticks after the falling edge was seen. A shorter low pulse produces no byte and no flag.
- R7: A received parity bit that differs from the expected value sets `err_parity`, and the byte is still delivered.
- R8: A low level at the first stop position sets `err_frame`, and the byte is still delivered.
- R9: A byte that completes while the receive buffer is full is discarded and sets `err_overrun`. The bytes already buffered are kept intact.
- R10: Error flags stay set until `err_clr` is high at a clock edge, which clears them. An error that arrives in that same cycle wins over the clear.
- R11: The buffers hold `TX_DEPTH` and `RX_DEPTH` bytes (default 190 each). `tx_ready` is low exactly while the transmit buffer is full. `rx_valid` and `rx_data` hold until `rx_ready` accepts the byte, and bytes keep their order.
- R12: Transmission and reception proceed simultaneously without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | DIV_W | Sample-tick divisor; one tick every cfg_div+1 clocks |
| cfg_eight | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_parity | input | 3 | Parity mode code (see R5) |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmit buffer can take a byte |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | rx_data holds a byte |
| rx_ready | input | 1 | Consumer takes rx_data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| err_clr | input | 1 | Clears the error flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky stop-bit error |
| err_overrun | output | 1 | Sticky lost-byte error |

## Verification
The hardest case to reach from the ports is an overrun. It needs a full receive buffer and then one more complete frame, and with the default depth that is nearly two hundred frames. The bench builds the block with four-entry buffers, sends five frames back to back while holding `rx_ready` low, then drains the buffer and checks that only the first four bytes are present. Broken frames never come from the block's own transmitter, so the bench drives `rxd` itself. It flips parity bits, pulls the first stop bit low just past its middle, and sends a start pulse too short to be confirmed. A seeded random mix of formats, with the two directions running at the same time, covers the common paths.

// File: rtl/flex_uart_pkg.sv
package flex_uart_pkg;

   localparam int OVS       = 16;
   localparam int OVS_W     = $clog2(OVS);
   localparam int OVS_MID   = OVS / 2 - 1;
   localparam int FRAME_MAX = 12;
   localparam int LEN_W     = 4;

   typedef enum logic [2:0] {
      PAR_NONE  = 3'd0,
      PAR_EVEN  = 3'd1,
      PAR_ODD   = 3'd2,
      PAR_MARK  = 3'd3,
      PAR_SPACE = 3'd4
   } par_mode_e;

   function automatic logic par_enabled(input logic [2:0] mode);
      return (mode == PAR_EVEN) || (mode == PAR_ODD) ||
             (mode == PAR_MARK) || (mode == PAR_SPACE);
   endfunction

   function automatic logic par_value(input logic [2:0] mode, input logic [7:0] d);
      logic v;
      case (mode)
         PAR_EVEN: v = ^d;
         PAR_ODD:  v = ~(^d);
         PAR_MARK: v = 1'b1;
         default:  v = 1'b0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/flex_uart_baud.sv
module flex_uart_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   assign tick_o = (cnt_q >= div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   initial begin
      assert (DIV_W >= 1) else $error("flex_uart_baud: DIV_W must be at least 1");
   end

endmodule

// File: rtl/flex_uart_fifo.sv
module flex_uart_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 190
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] dout_o,
   output logic             empty_o,
   output logic             full_o
);

   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = (DEPTH == (1 << AW));

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_q, rd_q, wr_nx, rd_nx;
   logic [CW-1:0]    cnt_q;
   logic             do_push, do_pop;

   assign full_o  = (cnt_q == CW'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign dout_o  = mem[rd_q];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nx = wr_q + 1'b1;
         assign rd_nx = rd_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nx = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nx = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_nx;
         if (do_pop)  rd_q <= rd_nx;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   initial begin
      assert (DEPTH >= 2) else $error("flex_uart_fifo: DEPTH must be at least 2");
      assert (WIDTH >= 1) else $error("flex_uart_fifo: WIDTH must be at least 1");
   end

   // R11
   fifo_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !full_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/flex_uart_tx.sv
module flex_uart_tx
   import flex_uart_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       eight_i,
   input  logic       two_stop_i,
   input  logic [2:0] parity_i,
   input  logic       fifo_empty_i,
   input  logic [7:0] fifo_data_i,
   output logic       fifo_pop_o,
   output logic       txd_o
);

   logic                 busy_q, txd_q;
   logic [OVS_W-1:0]     tcnt_q;
   logic [FRAME_MAX-1:0] sh_q, frame;
   logic [LEN_W-1:0]     left_q, nbits;
   logic                 pen, pv, launch;

   assign pen = par_enabled(parity_i);
   assign pv  = par_value(parity_i, eight_i ? fifo_data_i : {1'b0, fifo_data_i[6:0]});

   always_comb begin
      frame      = '1;
      frame[0]   = 1'b0;
      frame[7:1] = fifo_data_i[6:0];
      if (eight_i) begin
         frame[8] = fifo_data_i[7];
         if (pen) frame[9] = pv;
      end else if (pen) begin
         frame[8] = pv;
      end
      nbits = LEN_W'(1) + (eight_i ? LEN_W'(8) : LEN_W'(7)) +
              (pen ? LEN_W'(1) : LEN_W'(0)) + (two_stop_i ? LEN_W'(2) : LEN_W'(1));
   end

   assign launch     = tick_i && !busy_q && !fifo_empty_i;
   assign fifo_pop_o = launch;
   assign txd_o      = txd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         txd_q  <= 1'b1;
         tcnt_q <= '0;
         sh_q   <= '1;
         left_q <= '0;
      end else if (launch) begin
         busy_q <= 1'b1;
         txd_q  <= frame[0];
         sh_q   <= {1'b1, frame[FRAME_MAX-1:1]};
         left_q <= nbits - 1'b1;
         tcnt_q <= '0;
      end else if (busy_q && tick_i) begin
         if (tcnt_q == OVS_W'(OVS - 1)) begin
            tcnt_q <= '0;
            if (left_q == '0) begin
               busy_q <= 1'b0;
               txd_q  <= 1'b1;
            end else begin
               txd_q  <= sh_q[0];
               sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
               left_q <= left_q - 1'b1;
            end
         end else begin
            tcnt_q <= tcnt_q + 1'b1;
         end
      end
   end

   // R2
   txd_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(txd_o));

   // R2
   txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> txd_o);

endmodule

// File: rtl/flex_uart_rx.sv
module flex_uart_rx
   import flex_uart_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       rxd_i,
   input  logic       eight_i,
   input  logic [2:0] parity_i,
   output logic [7:0] byte_o,
   output logic       done_o,
   output logic       perr_o,
   output logic       ferr_o
);

   typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

   rx_state_e        st_q;
   logic             rxs;
   logic [OVS_W-1:0] tcnt_q;
   logic [2:0]       idx_q, last_idx;
   logic [7:0]       dat_q;
   logic             pbad_q, done_q, perr_q, ferr_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= rxd_i;
         end
         assign rxs = s_q;
      end else begin : g_sync_chain
         logic [SYNC_STAGES-1:0] ch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q <= '1;
            else        ch_q <= {ch_q[SYNC_STAGES-2:0], rxd_i};
         end
         assign rxs = ch_q[SYNC_STAGES-1];
      end
   endgenerate

   assign last_idx = eight_i ? 3'd7 : 3'd6;
   assign byte_o   = dat_q;
   assign done_o   = done_q;
   assign perr_o   = perr_q;
   assign ferr_o   = ferr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RX_IDLE;
         tcnt_q <= '0;
         idx_q  <= '0;
         dat_q  <= '0;
         pbad_q <= 1'b0;
         done_q <= 1'b0;
         perr_q <= 1'b0;
         ferr_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tick_i) begin
            case (st_q)
               RX_IDLE: begin
                  if (!rxs) begin
                     st_q   <= RX_START;
                     tcnt_q <= '0;
                  end
               end
               RX_START: begin
                  if (tcnt_q == OVS_W'(OVS_MID)) begin
                     tcnt_q <= '0;
                     if (!rxs) begin
                        st_q   <= RX_DATA;
                        idx_q  <= '0;
                        dat_q  <= '0;
                        pbad_q <= 1'b0;
                     end else begin
                        st_q <= RX_IDLE;
                     end
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (tcnt_q == OVS_W'(OVS - 1)) begin
                     tcnt_q       <= '0;
                     dat_q[idx_q] <= rxs;
                     if (idx_q == last_idx) st_q <= par_enabled(parity_i) ? RX_PAR : RX_STOP;
                     else                   idx_q <= idx_q + 1'b1;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (tcnt_q == OVS_W'(OVS - 1)) begin
                     tcnt_q <= '0;
                     pbad_q <= (rxs != par_value(parity_i, dat_q));
                     st_q   <= RX_STOP;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (tcnt_q == OVS_W'(OVS - 1)) begin
                     tcnt_q <= '0;
                     done_q <= 1'b1;
                     ferr_q <= !rxs;
                     perr_q <= pbad_q;
                     st_q   <= RX_IDLE;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   initial begin
      assert (SYNC_STAGES >= 1) else $error("flex_uart_rx: SYNC_STAGES must be at least 1");
   end

   // R6
   start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) == RX_START && st_q == RX_IDLE) |-> $past(rxs));

   // R3
   seven_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !eight_i) |-> !byte_o[7]);

endmodule

// File: rtl/flex_uart.sv
module flex_uart
   import flex_uart_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int TX_DEPTH    = 190,
   parameter int RX_DEPTH    = 190,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_eight,
   input  logic             cfg_two_stop,
   input  logic [2:0]       cfg_parity,
   input  logic [7:0]       tx_data,
   input  logic             tx_valid,
   output logic             tx_ready,
   output logic [7:0]       rx_data,
   output logic             rx_valid,
   input  logic             rx_ready,
   input  logic             rxd,
   output logic             txd,
   input  logic             err_clr,
   output logic             err_parity,
   output logic             err_frame,
   output logic             err_overrun
);

   logic       tick;
   logic       tx_full, tx_empty, tx_pop;
   logic [7:0] tx_head;
   logic       rx_full, rx_empty, rx_done, rx_perr, rx_ferr;
   logic [7:0] rx_byte;

   flex_uart_baud #(.DIV_W(DIV_W)) baud_i (
      .clk(clk), .rst_n(rst_n), .div_i(cfg_div), .tick_o(tick));

   flex_uart_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) txq_i (
      .clk(clk), .rst_n(rst_n),
      .push_i(tx_valid), .din_i(tx_data),
      .pop_i(tx_pop), .dout_o(tx_head),
      .empty_o(tx_empty), .full_o(tx_full));

   flex_uart_tx tx_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .eight_i(cfg_eight), .two_stop_i(cfg_two_stop), .parity_i(cfg_parity),
      .fifo_empty_i(tx_empty), .fifo_data_i(tx_head), .fifo_pop_o(tx_pop),
      .txd_o(txd));

   flex_uart_rx #(.SYNC_STAGES(SYNC_STAGES)) rx_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd),
      .eight_i(cfg_eight), .parity_i(cfg_parity),
      .byte_o(rx_byte), .done_o(rx_done), .perr_o(rx_perr), .ferr_o(rx_ferr));

   flex_uart_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) rxq_i (
      .clk(clk), .rst_n(rst_n),
      .push_i(rx_done), .din_i(rx_byte),
      .pop_i(rx_ready), .dout_o(rx_data),
      .empty_o(rx_empty), .full_o(rx_full));

   assign tx_ready = !tx_full;
   assign rx_valid = !rx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
      end else begin
         err_parity  <= (err_parity  && !err_clr) || (rx_done && rx_perr);
         err_frame   <= (err_frame   && !err_clr) || (rx_done && rx_ferr);
         err_overrun <= (err_overrun && !err_clr) || (rx_done && rx_full);
      end
   end

   // R9
   overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_overrun) |-> $past(rx_done && rx_full));

   // R7
   parity_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_parity) |-> $past(rx_done));

   // R10
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !rx_done) |=> (!err_parity && !err_frame && !err_overrun));

   // R11
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

endmodule

// File: tb/flex_uart_tb_top.sv
`timescale 1ns/1ps
module flex_uart_tb_top;

   localparam int DIVV  = 1;
   localparam int BIT   = 16 * (DIVV + 1);
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_div = 16'(DIVV);
   logic        cfg_eight = 1'b1, cfg_two = 1'b0;
   logic [2:0]  cfg_par = 3'd0;
   logic [7:0]  tx_data = 8'h00;
   logic        tx_valid = 1'b0, rx_ready = 1'b0, rxd_drv = 1'b1, err_clr = 1'b0;
   logic        tx_ready, rx_valid, txd, err_parity, err_frame, err_overrun;
   logic [7:0]  rx_data;

   int checks = 0, fails = 0, n_acc = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   flex_uart #(.DIV_W(16), .TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_eight(cfg_eight),
      .cfg_two_stop(cfg_two), .cfg_parity(cfg_par),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .rxd(rxd_drv), .txd(txd), .err_clr(err_clr),
      .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun));

   function automatic bit has_par(input logic [2:0] m);
      return (m >= 3'd1) && (m <= 3'd4);
   endfunction

   function automatic bit exp_par(input logic [2:0] m, input logic [7:0] d, input bit eight);
      logic [7:0] dd = eight ? d : (d & 8'h7F);
      case (m)
         3'd1: return ^dd;
         3'd2: return ~(^dd);
         3'd3: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic int flen(input bit eight, input bit two, input logic [2:0] m);
      return 1 + (eight ? 8 : 7) + (has_par(m) ? 1 : 0) + (two ? 2 : 1);
   endfunction

   function automatic logic [11:0] exp_frame(input logic [7:0] d, input bit eight,
                                             input bit two, input logic [2:0] m);
      logic [11:0] v = '1;
      int k = 1;
      v[0] = 1'b0;
      for (int i = 0; i < (eight ? 8 : 7); i++) begin v[k] = d[i]; k++; end
      if (has_par(m)) v[k] = exp_par(m, d, eight);
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_cfg(input bit eight, input bit two, input logic [2:0] m);
      @(negedge clk);
      cfg_eight = eight; cfg_two = two; cfg_par = m;
   endtask

   task automatic push_tx(input logic [7:0] d);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_data = d; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic watch_tx(input logic [7:0] d, input bit eight, input bit two,
                           input logic [2:0] m, input string req);
      int n = flen(eight, two, m);
      logic [11:0] got = '1, exp = exp_frame(d, eight, two, m);
      logic [11:0] mask = 12'((1 << n) - 1);
      @(negedge clk);
      while (txd !== 1'b0) @(negedge clk);
      repeat (BIT / 2) @(negedge clk);
      got[0] = txd;
      for (int k = 1; k < n; k++) begin
         repeat (BIT) @(negedge clk);
         got[k] = txd;
      end
      check(((got ^ exp) & mask) == 12'h0, req, int'(got & mask), int'(exp & mask));
   endtask

   task automatic drive_frame(input logic [7:0] d, input bit eight, input bit two,
                              input logic [2:0] m, input bit bad_par, input bit bad_stop);
      logic [11:0] v = exp_frame(d, eight, two, m);
      int n  = flen(eight, two, m);
      int sp = 1 + (eight ? 8 : 7) + (has_par(m) ? 1 : 0);
      if (bad_par) v[sp-1] = ~v[sp-1];
      for (int k = 0; k < n; k++) begin
         if (bad_stop && k == sp) begin
            rxd_drv = 1'b0;
            repeat (BIT / 2 + 10) @(negedge clk);
            rxd_drv = 1'b1;
            repeat (BIT / 2 - 10) @(negedge clk);
         end else begin
            rxd_drv = v[k];
            repeat (BIT) @(negedge clk);
         end
      end
      rxd_drv = 1'b1;
   endtask

   task automatic pop_check(input logic [7:0] exp, input string req);
      @(negedge clk);
      check(rx_valid === 1'b1 && rx_data === exp, req, int'({rx_valid, rx_data}), int'({1'b1, exp}));
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
   endtask

   task automatic clear_flags(input string req);
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      check({err_parity, err_frame, err_overrun} == 3'b000, req,
            int'({err_parity, err_frame, err_overrun}), 0);
   endtask

   task automatic flags_check(input logic [2:0] exp, input string req);
      check({err_parity, err_frame, err_overrun} == exp, req,
            int'({err_parity, err_frame, err_overrun}), int'(exp));
   endtask

   initial begin
      void'($urandom(32'd90215));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check({txd, tx_ready, rx_valid, err_parity, err_frame, err_overrun} == 6'b110000, "R1",
            int'({txd, tx_ready, rx_valid, err_parity, err_frame, err_overrun}), 6'b110000);

      // R2 directed 8N1 transmit
      set_cfg(1, 0, 3'd0);
      fork
         push_tx(8'hA5);
         watch_tx(8'hA5, 1, 0, 3'd0, "R2");
      join

      // R3 R4 R5 R12 random formats, both directions at once
      for (int it = 0; it < 20; it++) begin
         logic [7:0] d1 = 8'($urandom);
         logic [7:0] d2 = 8'($urandom);
         bit e = 1'($urandom);
         bit t = 1'($urandom);
         logic [2:0] m = 3'($urandom % 6);
         set_cfg(e, t, m);
         fork
            push_tx(d1);
            watch_tx(d1, e, t, m, "R12 tx R3 R4 R5");
            begin @(negedge clk); drive_frame(d2, e, t, m, 0, 0); end
         join
         repeat (4) @(negedge clk);
         flags_check(3'b000, "R12 rx flags R5");
         pop_check(e ? d2 : (d2 & 8'h7F), "R12 rx data R3");
      end

      // R3 seven-bit mode with odd parity, both directions
      set_cfg(0, 0, 3'd2);
      fork
         push_tx(8'h95);
         watch_tx(8'h95, 0, 0, 3'd2, "R3 tx bit7 ignored");
         begin @(negedge clk); drive_frame(8'hFF, 0, 0, 3'd2, 0, 0); end
      join
      repeat (4) @(negedge clk);
      pop_check(8'h7F, "R3 rx bit7 zero");

      // R7 parity error, R10 stickiness
      set_cfg(1, 0, 3'd1);
      drive_frame(8'h3C, 1, 0, 3'd1, 1, 0);
      repeat (4) @(negedge clk);
      flags_check(3'b100, "R7 parity flag");
      drive_frame(8'h5A, 1, 0, 3'd1, 0, 0);
      repeat (4) @(negedge clk);
      flags_check(3'b100, "R10 sticky");
      pop_check(8'h3C, "R7 byte kept");
      pop_check(8'h5A, "R10 next byte");
      clear_flags("R10 clear");

      // R5 mark parity received as zero
      set_cfg(1, 1, 3'd3);
      drive_frame(8'h00, 1, 1, 3'd3, 1, 0);
      repeat (4) @(negedge clk);
      flags_check(3'b100, "R5 mark mismatch");
      pop_check(8'h00, "R5 mark byte");
      clear_flags("R10 clear mark");

      // R8 framing error
      set_cfg(1, 0, 3'd0);
      drive_frame(8'hC3, 1, 0, 3'd0, 0, 1);
      repeat (BIT * 2) @(negedge clk);
      flags_check(3'b010, "R8 frame flag");
      pop_check(8'hC3, "R8 byte kept");
      check(rx_valid === 1'b0, "R8 no extra byte", int'(rx_valid), 0);
      clear_flags("R10 clear frame");

      // R6 short start pulse
      @(negedge clk);
      rxd_drv = 1'b0;
      repeat (8) @(negedge clk);
      rxd_drv = 1'b1;
      repeat (BIT * 12) @(negedge clk);
      check(rx_valid === 1'b0 && !err_frame && !err_parity, "R6 glitch ignored",
            int'({rx_valid, err_frame, err_parity}), 0);

      // R9 overrun
      for (int i = 0; i <= DEPTH; i++) drive_frame(8'(8'h11 * (i + 1)), 1, 0, 3'd0, 0, 0);
      repeat (4) @(negedge clk);
      flags_check(3'b001, "R9 overrun flag");
      for (int i = 0; i < DEPTH; i++) pop_check(8'(8'h11 * (i + 1)), "R9 kept order");
      @(negedge clk);
      check(rx_valid === 1'b0, "R9 last byte dropped", int'(rx_valid), 0);
      clear_flags("R10 clear overrun");

      // R11 transmit buffer fill and order
      fork
         begin
            n_acc = 0;
            @(negedge clk);
            for (int g = 0; g < 20; g++) begin
               if (!tx_ready) break;
               tx_data = 8'(8'h90 + n_acc);
               tx_valid = 1'b1;
               n_acc++;
               @(negedge clk);
            end
            tx_valid = 1'b0;
         end
         for (int j = 0; j <= DEPTH; j++) watch_tx(8'(8'h90 + j), 1, 0, 3'd0, "R11 tx order");
      join
      check(n_acc == DEPTH + 1, "R11 tx_ready backpressure", n_acc, DEPTH + 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=expired expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule